// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Guard

This block holds the status bits of a small serial flash with a 17-bit byte address and decides whether each decoded instruction runs. An upstream serial front end hands over one instruction per cycle as an opcode, a target address and, for a status write, a data byte. The block then answers with exactly one of three results: it accepts the instruction, it rejects it, or it ignores it. When a status write, program or erase is accepted, it starts the internal operation by pulsing `op_start` with a job code and the target address. It then stays busy until a modelled program/erase timer pulses `op_done`.

The guard combines four conditions: the write-enable bit, the busy state, an address-range protection zone, and a hardware lock. The lock is in force when the lock bit is set and the write-protect pin is low. The lock bit and the two zone bits stand in for non-volatile storage. They are cleared only by the power-on reset `rst_n`. The soft reset `soft_rst` clears only the busy and write-enable bits.

Top module: `flash_guard`

## Requirements
- R1: After power-on reset every output is 0, and a status read returns 0x00.
- R2: A status read (opcode 0x05) is accepted in any state, busy included. One cycle after the instruction, `rd_valid` pulses and `rd_data` holds the status byte as it stood before that cycle's update. The byte layout is bit0 busy, bit1 write-enable, bits3:2 zone, bit7 lock, and bits 6:4 always read as 0.
- R3: When idle, opcode 0x06 sets the write-enable bit and opcode 0x04 clears it. Both are accepted. No instruction produces accept and reject together.
- R4: With write-enable at 0, a status write (0x01), page program (0x02), block erase (0xD8) or chip erase (0xC7) is rejected. It starts nothing and changes no status bit.
- R5: An accepted status write, program or erase pulses `op_start` one cycle later. `op_job` is 0 for a status write, 1 for a program, 2 for a block erase and 3 for a chip erase. `op_addr` carries the instruction's address. Busy reads 1 from that cycle on, and an `op_done` while busy returns both busy and write-enable to 0.
- R6: While busy, every instruction other than a status read is ignored: no accept, no reject, no start and no bit change.
- R7: A program or block erase is rejected when its address lies in the protected zone. Zone 01 protects 0x18000 and above, zone 10 protects 0x10000 and above, and zone 11 protects the whole array. A rejection for protection clears write-enable and never sets busy.
- R8: A chip erase is accepted only when both zone bits are 0. Otherwise it is rejected and write-enable is cleared.
- R9: When the lock bit is 1 and `wp_n` is 0, a status write is rejected and write-enable is cleared. In that state the lock and zone bits do not change.
- R10: An accepted status write loads the lock bit from data bit 7 and the zone bits from data bits 3:2. All other data bits are dropped.
- R11: `soft_rst` clears busy and write-enable and keeps the lock and zone bits. An instruction in the same cycle is ignored.
- R12: An opcode outside the seven listed is ignored and changes no bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, clears all bits |
| soft_rst | input | 1 | Synchronous soft reset of the volatile bits |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_valid | input | 1 | A decoded instruction is present this cycle |
| cmd_opcode | input | 8 | Instruction opcode |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_wdata | input | 8 | Data byte for a status write |
| op_done | input | 1 | Completion pulse from the program/erase timer |
| cmd_accept | output | 1 | Instruction accepted |
| cmd_reject | output | 1 | Instruction refused |
| op_start | output | 1 | Internal operation starts |
| op_job | output | 2 | Kind of operation started |
| op_addr | output | ADDR_W | Address of the started operation |
| rd_valid | output | 1 | Status byte valid |
| rd_data | output | 8 | Status byte |

## Verification
The bench targets the zone boundaries on both sides. These are 0x17FFF against 0x18000, and 0x0FFFF against 0x10000. A design with an off-by-one range would program a protected byte or refuse an open one. It also targets a chip erase under a nonzero zone, which a design that checks only the address would start. It toggles `wp_n` under a set lock bit; a design that ignores the pin, or that honours it with the lock bit clear, would let a status write through or block a legal one. It sends instructions while busy, together with a soft reset in the middle of an operation. A design that wrongly clears the zone bits on soft reset, or that lets a write-enable through during busy, is caught by the status byte read back afterwards.

// File: rtl/flash_guard_pkg.sv
`timescale 1ns/1ps
package flash_guard_pkg;

  localparam logic [7:0] OPC_WR_EN     = 8'h06;
  localparam logic [7:0] OPC_WR_DIS    = 8'h04;
  localparam logic [7:0] OPC_STAT_RD   = 8'h05;
  localparam logic [7:0] OPC_STAT_WR   = 8'h01;
  localparam logic [7:0] OPC_PROG      = 8'h02;
  localparam logic [7:0] OPC_BLK_ERASE = 8'hD8;
  localparam logic [7:0] OPC_ALL_ERASE = 8'hC7;

  typedef enum logic [1:0] {
    JOB_STAT_WR   = 2'd0,
    JOB_PROG      = 2'd1,
    JOB_BLK_ERASE = 2'd2,
    JOB_ALL_ERASE = 2'd3
  } job_e;

  // status byte, MSB first
  typedef struct packed {
    logic       lock;
    logic [2:0] zero;
    logic [1:0] zone;
    logic       wen;
    logic       busy;
  } stat_t;

  typedef struct packed {
    logic wr_en;
    logic wr_dis;
    logic stat_rd;
    logic stat_wr;
    logic prog;
    logic blk_erase;
    logic all_erase;
  } cls_t;

endpackage

// File: rtl/flash_guard_decode.sv
`timescale 1ns/1ps
module flash_guard_decode
  import flash_guard_pkg::*;
(
  input  logic [7:0] opcode_i,
  output cls_t       cls_o
);

  always_comb begin
    cls_o = '0;
    case (opcode_i)
      OPC_WR_EN:     cls_o.wr_en     = 1'b1;
      OPC_WR_DIS:    cls_o.wr_dis    = 1'b1;
      OPC_STAT_RD:   cls_o.stat_rd   = 1'b1;
      OPC_STAT_WR:   cls_o.stat_wr   = 1'b1;
      OPC_PROG:      cls_o.prog      = 1'b1;
      OPC_BLK_ERASE: cls_o.blk_erase = 1'b1;
      OPC_ALL_ERASE: cls_o.all_erase = 1'b1;
      default:       cls_o = '0;
    endcase
  end

endmodule

// File: rtl/flash_guard_prot.sv
`timescale 1ns/1ps
module flash_guard_prot #(
  parameter int ADDR_W = 17
) (
  input  logic [1:0]        zone_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);

  localparam int TOP = ADDR_W - 1;

  logic in_top_half;
  logic in_top_quarter;

  assign in_top_half    = addr_i[TOP];
  assign in_top_quarter = addr_i[TOP] & addr_i[TOP-1];

  always_comb begin
    case (zone_i)
      2'b00:   hit_o = 1'b0;
      2'b01:   hit_o = in_top_quarter;
      2'b10:   hit_o = in_top_half;
      default: hit_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/flash_guard_sreg.sv
`timescale 1ns/1ps
module flash_guard_sreg
  import flash_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_clr_i,
  input  logic       wen_set_i,
  input  logic       wen_clr_i,
  input  logic       busy_set_i,
  input  logic       busy_clr_i,
  input  logic       nv_we_i,
  input  logic       nv_lock_i,
  input  logic [1:0] nv_zone_i,
  output stat_t      stat_o
);

  logic       busy_q, busy_d, busy_en;
  logic       wen_q, wen_d, wen_en;
  logic       lock_q;
  logic [1:0] zone_q;

  // next state
  always_comb begin
    busy_en = soft_clr_i | busy_set_i | busy_clr_i;
    if (soft_clr_i)      busy_d = 1'b0;
    else if (busy_set_i) busy_d = 1'b1;
    else                 busy_d = 1'b0;

    wen_en = soft_clr_i | wen_set_i | wen_clr_i;
    if (soft_clr_i || wen_clr_i) wen_d = 1'b0;
    else                         wen_d = 1'b1;
  end

  // volatile bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wen_q  <= 1'b0;
    end else begin
      if (busy_en) busy_q <= busy_d;
      if (wen_en)  wen_q  <= wen_d;
    end
  end

  // bits standing in for non-volatile storage: power-on reset only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      zone_q <= 2'b00;
    end else if (nv_we_i) begin
      lock_q <= nv_lock_i;
      zone_q <= nv_zone_i;
    end
  end

  always_comb begin
    stat_o      = '0;
    stat_o.busy = busy_q;
    stat_o.wen  = wen_q;
    stat_o.zone = zone_q;
    stat_o.lock = lock_q;
  end

  AST_SOFT_CLR_KEEPS_NV: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr_i |=> (!busy_q && !wen_q && $stable({lock_q, zone_q}))); // R11
  AST_NV_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !nv_we_i |=> $stable({lock_q, zone_q})); // R10

endmodule

// File: rtl/flash_guard.sv
`timescale 1ns/1ps
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wp_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_opcode,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_wdata,
  input  logic              op_done,
  output logic              cmd_accept,
  output logic              cmd_reject,
  output logic              op_start,
  output logic [1:0]        op_job,
  output logic [ADDR_W-1:0] op_addr,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  cls_t  cls;
  stat_t stat;
  logic  prot_hit;

  flash_guard_decode u_decode (
    .opcode_i (cmd_opcode),
    .cls_o    (cls)
  );

  flash_guard_prot #(.ADDR_W(ADDR_W)) u_prot (
    .zone_i (stat.zone),
    .addr_i (cmd_addr),
    .hit_o  (prot_hit)
  );

  // decision
  logic live, idle, hw_lock, wants_write, guard_fail;
  logic go, no_wen, refuse_prot, launch, finish;
  logic wen_set, wen_clr, nv_we;
  job_e job_d;

  always_comb begin
    live        = cmd_valid & ~soft_rst;
    idle        = ~stat.busy;
    hw_lock     = stat.lock & ~wp_n;
    wants_write = cls.stat_wr | cls.prog | cls.blk_erase | cls.all_erase;

    if (cls.stat_wr)                      guard_fail = hw_lock;
    else if (cls.prog || cls.blk_erase)   guard_fail = prot_hit;
    else if (cls.all_erase)               guard_fail = |stat.zone;
    else                                  guard_fail = 1'b0;

    go          = live & idle & wants_write;
    no_wen      = go & ~stat.wen;
    refuse_prot = go & stat.wen & guard_fail;
    launch      = go & stat.wen & ~guard_fail;
    finish      = stat.busy & op_done;

    wen_set = live & idle & cls.wr_en;
    wen_clr = (live & idle & cls.wr_dis) | refuse_prot | finish;
    nv_we   = launch & cls.stat_wr;

    if (cls.prog)           job_d = JOB_PROG;
    else if (cls.blk_erase) job_d = JOB_BLK_ERASE;
    else if (cls.all_erase) job_d = JOB_ALL_ERASE;
    else                    job_d = JOB_STAT_WR;
  end

  flash_guard_sreg u_sreg (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .soft_clr_i (soft_rst),
    .wen_set_i  (wen_set),
    .wen_clr_i  (wen_clr),
    .busy_set_i (launch),
    .busy_clr_i (finish),
    .nv_we_i    (nv_we),
    .nv_lock_i  (cmd_wdata[7]),
    .nv_zone_i  (cmd_wdata[3:2]),
    .stat_o     (stat)
  );

  // output next state
  logic              accept_d, reject_d, rd_en;
  always_comb begin
    rd_en    = live & cls.stat_rd;
    accept_d = launch | rd_en | (live & idle & (cls.wr_en | cls.wr_dis));
    reject_d = no_wen | refuse_prot;
  end

  // output registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cmd_accept <= 1'b0;
      cmd_reject <= 1'b0;
      op_start   <= 1'b0;
      rd_valid   <= 1'b0;
      op_job     <= 2'b00;
      op_addr    <= '0;
      rd_data    <= 8'h00;
    end else begin
      cmd_accept <= accept_d;
      cmd_reject <= reject_d;
      op_start   <= launch;
      rd_valid   <= rd_en;
      if (launch) begin
        op_job  <= job_d;
        op_addr <= cmd_addr;
      end
      if (rd_en) rd_data <= stat;
    end
  end

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_accept && cmd_reject)); // R3
  AST_READ_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[6:4] == 3'b000)); // R2
  AST_NEED_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !stat.wen) |=> !op_start); // R4
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> stat.busy); // R5
  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat.busy && cmd_valid && cmd_opcode != OPC_STAT_RD) |=> (!cmd_accept && !cmd_reject)); // R6
  AST_ZONE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && prot_hit && (cls.prog || cls.blk_erase)) |=> !op_start); // R7
  AST_ALL_ERASE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cls.all_erase && stat.zone != 2'b00) |=> !op_start); // R8
  AST_HW_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat.lock && !wp_n) |=> $stable({stat.lock, stat.zone})); // R9

endmodule

// File: tb/sim_flash_guard.sv
`timescale 1ns/1ps
module sim_flash_guard;

  logic        clk = 1'b0;
  logic        rst_n, soft_rst, wp_n, cmd_valid, op_done;
  logic [7:0]  cmd_opcode, cmd_wdata;
  logic [16:0] cmd_addr;
  logic        cmd_accept, cmd_reject, op_start, rd_valid;
  logic [1:0]  op_job;
  logic [16:0] op_addr;
  logic [7:0]  rd_data;

  int n_checks = 0;
  int n_errors = 0;

  // reference state
  logic       m_busy, m_wen, m_lock;
  logic [1:0] m_zone;

  always #4 clk = ~clk;

  flash_guard u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wp_n(wp_n),
    .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .op_done(op_done), .cmd_accept(cmd_accept),
    .cmd_reject(cmd_reject), .op_start(op_start), .op_job(op_job),
    .op_addr(op_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [7:0] sbyte();
    return {m_lock, 3'b000, m_zone, m_wen, m_busy};
  endfunction

  function automatic logic zone_hit(input logic [1:0] z, input logic [16:0] a);
    case (z)
      2'b00:   return 1'b0;
      2'b01:   return a >= 17'h18000;
      2'b10:   return a >= 17'h10000;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input string tag, input logic [30:0] act, input logic [30:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [7:0] op,
                      input logic [16:0] a, input logic [7:0] d,
                      input logic wp, input logic dn, input logic sr);
    logic e_acc, e_rej, e_st, e_rv;
    logic [1:0] e_job;
    logic [7:0] e_rd;
    logic n_busy, n_wen, n_lock;
    logic [1:0] n_zone;
    logic [30:0] act, exp;
    @(negedge clk);
    cmd_valid = v; cmd_opcode = op; cmd_addr = a; cmd_wdata = d;
    wp_n = wp; op_done = dn; soft_rst = sr;
    e_acc = 0; e_rej = 0; e_st = 0; e_rv = 0; e_job = 2'd0; e_rd = 8'h00;
    n_busy = m_busy; n_wen = m_wen; n_lock = m_lock; n_zone = m_zone;
    if (sr) begin
      n_busy = 0; n_wen = 0;
    end else begin
      if (m_busy && dn) begin n_busy = 0; n_wen = 0; end
      if (v) begin
        if (op == 8'h05) begin e_acc = 1; e_rv = 1; e_rd = sbyte(); end
        else if (!m_busy) begin
          case (op)
            8'h06: begin e_acc = 1; n_wen = 1; end
            8'h04: begin e_acc = 1; n_wen = 0; end
            8'h01: if (!m_wen) e_rej = 1;
                   else if (m_lock && !wp) begin e_rej = 1; n_wen = 0; end
                   else begin e_acc = 1; e_st = 1; e_job = 2'd0; n_busy = 1;
                              n_lock = d[7]; n_zone = d[3:2]; end
            8'h02, 8'hD8: if (!m_wen) e_rej = 1;
                   else if (zone_hit(m_zone, a)) begin e_rej = 1; n_wen = 0; end
                   else begin e_acc = 1; e_st = 1; e_job = (op == 8'h02) ? 2'd1 : 2'd2;
                              n_busy = 1; end
            8'hC7: if (!m_wen) e_rej = 1;
                   else if (m_zone != 2'b00) begin e_rej = 1; n_wen = 0; end
                   else begin e_acc = 1; e_st = 1; e_job = 2'd3; n_busy = 1; end
            default: ;
          endcase
        end
      end
    end
    @(posedge clk);
    #1;
    act = {cmd_accept, cmd_reject, op_start, rd_valid,
           op_start ? op_job : 2'd0, rd_valid ? rd_data : 8'h00,
           op_start ? op_addr : 17'h0};
    exp = {e_acc, e_rej, e_st, e_rv, e_job, e_rd, e_st ? a : 17'h0};
    check(tag, act, exp);
    m_busy = n_busy; m_wen = n_wen; m_lock = n_lock; m_zone = n_zone;
  endtask

  task automatic cmd(input string tag, input logic [7:0] op, input logic [16:0] a,
                     input logic [7:0] d, input logic wp);
    step(tag, 1'b1, op, a, d, wp, 1'b0, 1'b0);
  endtask

  task automatic done_pulse(input string tag);
    step(tag, 1'b0, 8'h00, 17'h0, 8'h00, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic expect_status(input string tag, input logic [7:0] val);
    n_checks++;
    if (sbyte() !== val) begin
      n_errors++;
      $display("FAIL %s (reference state): actual=%h expected=%h", tag, sbyte(), val);
    end
    cmd(tag, 8'h05, 17'h0, 8'h00, 1'b1);
  endtask

  initial begin
    #(8 * 200000);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 0; soft_rst = 0; wp_n = 1; cmd_valid = 0; op_done = 0;
    cmd_opcode = 8'h00; cmd_addr = 17'h0; cmd_wdata = 8'h00;
    m_busy = 0; m_wen = 0; m_lock = 0; m_zone = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    check("R1 outputs in reset", {cmd_accept, cmd_reject, op_start, rd_valid, op_job, rd_data, op_addr}, 31'h0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    step("R1 idle after reset", 1'b0, 8'h00, 17'h0, 8'h00, 1'b1, 1'b0, 1'b0);
    expect_status("R1 status after reset", 8'h00);

    cmd("R4 program without write-enable", 8'h02, 17'h00010, 8'h00, 1'b1);
    cmd("R4 chip erase without write-enable", 8'hC7, 17'h0, 8'h00, 1'b1);
    cmd("R3 write-enable", 8'h06, 17'h0, 8'h00, 1'b1);
    expect_status("R2 status with write-enable", 8'h02);
    cmd("R3 write-disable", 8'h04, 17'h0, 8'h00, 1'b1);
    expect_status("R3 status after disable", 8'h00);

    cmd("R3 enable", 8'h06, 17'h0, 8'h00, 1'b1);
    cmd("R10 status write all ones", 8'h01, 17'h00123, 8'hFF, 1'b1);
    cmd("R6 enable ignored while busy", 8'h06, 17'h0, 8'h00, 1'b1);
    cmd("R6 program ignored while busy", 8'h02, 17'h0, 8'h00, 1'b1);
    expect_status("R2 status read while busy", 8'h8F);
    done_pulse("R5 completion");
    expect_status("R5 busy and enable cleared", 8'h8C);

    cmd("R3 enable", 8'h06, 17'h0, 8'h00, 1'b1);
    cmd("R8 chip erase with zone 11", 8'hC7, 17'h0, 8'h00, 1'b1);
    expect_status("R8 enable cleared on refusal", 8'h8C);
    cmd("R3 enable", 8'h06, 17'h0, 8'h00, 1'b0);
    cmd("R9 status write under hardware lock", 8'h01, 17'h0, 8'h00, 1'b0);
    expect_status("R9 bits kept, enable cleared", 8'h8C);

    cmd("R3 enable", 8'h06, 17'h0, 8'h00, 1'b1);
    cmd("R9 status write with pin high", 8'h01, 17'h0, 8'h84, 1'b1);
    done_pulse("R5 completion");
    expect_status("R10 zone 01 with lock", 8'h84);

    cmd("R3 enable", 8'h06, 17'h0, 8'h00, 1'b1);
    cmd("R7 program at 0x18000 zone 01", 8'h02, 17'h18000, 8'h00, 1'b1);
    cmd("R3 enable", 8'h06, 17'h0, 8'h00, 1'b1);
    cmd("R7 program at 0x17FFF zone 01", 8'h02, 17'h17FFF, 8'h00, 1'b1);
    done_pulse("R5 completion");

    cmd("R3 enable", 8'h06, 17'h0, 8'h00, 1'b1);
    cmd("R5 block erase start", 8'hD8, 17'h00000, 8'h00, 1'b1);
    step("R11 soft reset during busy", 1'b1, 8'h06, 17'h0, 8'h00, 1'b1, 1'b0, 1'b1);
    expect_status("R11 zone and lock kept", 8'h84);

    cmd("R3 enable", 8'h06, 17'h0, 8'h00, 1'b1);
    cmd("R12 unknown opcode", 8'h9F, 17'h0, 8'hFF, 1'b1);
    expect_status("R12 nothing changed", 8'h86);

    cmd("R10 status write zone 10", 8'h01, 17'h0, 8'h78, 1'b1);
    done_pulse("R5 completion");
    expect_status("R10 zone 10, pad bits dropped", 8'h08);
    cmd("R3 enable", 8'h06, 17'h0, 8'h00, 1'b1);
    cmd("R7 block erase at 0x10000 zone 10", 8'hD8, 17'h10000, 8'h00, 1'b1);
    cmd("R3 enable", 8'h06, 17'h0, 8'h00, 1'b1);
    cmd("R7 block erase at 0x0FFFF zone 10", 8'hD8, 17'h0FFFF, 8'h00, 1'b1);
    done_pulse("R5 completion");
    cmd("R3 enable", 8'h06, 17'h0, 8'h00, 1'b1);
    cmd("R9 status write, lock clear, pin low", 8'h01, 17'h0, 8'h00, 1'b0);
    done_pulse("R5 completion");
    cmd("R3 enable", 8'h06, 17'h0, 8'h00, 1'b1);
    cmd("R8 chip erase with zone 00", 8'hC7, 17'h0, 8'h00, 1'b1);
    done_pulse("R5 completion");
    expect_status("R5 after chip erase", 8'h00);

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] op;
      case ($urandom_range(0, 9))
        0, 1: op = 8'h06;
        2:    op = 8'h04;
        3:    op = 8'h05;
        4:    op = 8'h01;
        5:    op = 8'h02;
        6:    op = 8'hD8;
        7:    op = 8'hC7;
        8:    op = 8'h06;
        default: op = 8'($urandom);
      endcase
      step("R2..R12 random", ($urandom_range(0, 3) != 0), op, 17'($urandom),
           8'($urandom), ($urandom_range(0, 2) != 0), ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 99) == 0));
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule